// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address stream for a memory that transfers data in bursts of four beats. A burst begins when either of two start strobes is high at a clock edge. The full external address is then captured. On later cycles only the two lowest address bits change. They follow a 2-bit beat index that steps forward when the active-low advance input is low and holds when it is high. The upper bits stay at the captured value until the next start.

A static order input picks how the beat index maps onto the low bits. One choice is a linear count that wraps modulo four. The other is an interleaved order, where the low bits are the starting low bits XOR the beat index. The beat index is also brought out, so that a controller or a checker can tell which beat of the burst is in progress. A parameter can tie the order to a fixed value instead of the pin; this models a pin that is left unconnected, which defaults to interleaved.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after reset, `addr_o` is all zeros and `beat_o` is 0.
- R2: If `start_a_i` or `start_b_i` (active high) is 1 at a rising edge, then after that edge `addr_o` equals the `addr_i` sampled at that edge and `beat_o` is 0. Either strobe alone, or both together, has the same effect.
- R3: With both start strobes at 0 and `adv_ni` at 0, `beat_o` increases by one modulo 4 at each edge.
- R4: With both start strobes at 0 and `adv_ni` at 1, `beat_o` and `addr_o` do not change at the edge.
- R5: A start strobe takes priority over `adv_ni` = 0 in the same cycle: the edge loads the address and sets `beat_o` to 0.
- R6: Bits `[ADDR_W-1:2]` of `addr_o` change only at an edge where a start strobe is high. A change on `addr_i` with no start strobe has no effect on `addr_o`.
- R7: With `mode_i` = 0 (linear), `addr_o[1:0]` = (start low bits + `beat_o`) mod 4.
- R8: With `mode_i` = 1 (interleaved), `addr_o[1:0]` = start low bits XOR `beat_o`. For example, a start of 01 gives 01, 00, 11, 10.
- R9: A fourth advance wraps the burst: `beat_o` returns to 0, `addr_o[1:0]` returns to the starting low bits, and the sequence repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_a_i | input | 1 | Burst start strobe A, active high |
| start_b_i | input | 1 | Burst start strobe B, active high |
| adv_ni | input | 1 | Advance: 0 steps to the next beat, 1 holds |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear; static during a burst |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Beat index within the burst |

## Verification
A corrupted beat counter shows on `beat_o`, and on the low bits of `addr_o`, at the first edge after the fault. That is one cycle later at most. A wrong order mapping changes only beats 1 to 3: beat 0 always equals the start bits, so the check needs at least one advance after every start. A stale or leaking base register shows in the upper address bits as soon as `addr_i` moves without a start. For this reason the random stimulus changes `addr_i` on every cycle.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  function automatic beat_t map_low(beat_t start, beat_t k, logic il);
    return il ? (start ^ k) : beat_t'(start + k);
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  output beat_t beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (load_i) beat_o <= '0;
    else if (step_i) beat_o <= beat_o + beat_t'(1);
  end

  // R3
  step_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> beat_o == beat_t'($past(beat_o) + 1'b1));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(beat_o));
  // R5
  load_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_o <= '0;
    else if (load_i) base_o <= addr_i;
  end

  // R6
  base_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter bit MODE_PIN_EN      = 1'b1,
  parameter bit FIXED_INTERLEAVE = 1'b1
) (
  input  logic  mode_i,
  input  beat_t start_i,
  input  beat_t beat_i,
  output beat_t low_o
);
  logic il;

  generate
    if (MODE_PIN_EN) begin : g_pin
      assign il = mode_i;
    end else begin : g_fixed
      assign il = FIXED_INTERLEAVE;
    end
  endgenerate

  assign low_o = map_low(start_i, beat_i, il);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W           = 18,
  parameter bit MODE_PIN_EN      = 1'b1,
  parameter bit FIXED_INTERLEAVE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_a_i,
  input  logic              start_b_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base;
  beat_t             beat;
  beat_t             low;

  assign load = start_a_i | start_b_i;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk_i, .rst_ni, .load_i(load), .addr_i, .base_o(base)
  );

  burst_beat_ctr u_ctr (
    .clk_i, .rst_ni, .load_i(load), .step_i(!adv_ni), .beat_o(beat)
  );

  burst_order_map #(
    .MODE_PIN_EN(MODE_PIN_EN), .FIXED_INTERLEAVE(FIXED_INTERLEAVE)
  ) u_map (
    .mode_i, .start_i(base[BEAT_W-1:0]), .beat_i(beat), .low_o(low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (addr_o == $past(addr_i)) && (beat_o == 2'd0));
  // R6
  upper_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1 -: HI_W] == $past(addr_o[ADDR_W-1 -: HI_W]));
  // R9
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !adv_ni && beat_o == 2'd3) |=> beat_o == 2'd0);
endmodule

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int ADDR_W = 18;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_a, start_b, adv_n, mode;
  logic [ADDR_W-1:0] addr_in, addr_out;
  logic [1:0] beat_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [ADDR_W-1:0] m_base;
  logic [1:0] m_beat;
  logic m_mode;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_a_i(start_a), .start_b_i(start_b),
    .adv_ni(adv_n), .mode_i(mode), .addr_i(addr_in),
    .addr_o(addr_out), .beat_o(beat_out)
  );

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] b,
                                                 logic [1:0] k, logic il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ k) : 2'(b[1:0] + k);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, check after
  task automatic step(logic sa, logic sb, logic an, logic md,
                      logic [ADDR_W-1:0] a);
    string t_beat, t_addr;
    @(negedge clk);
    start_a = sa; start_b = sb; adv_n = an; mode = md; addr_in = a;
    @(posedge clk);
    if (sa | sb) begin
      m_base = a; m_beat = 2'd0; m_mode = md;
      t_beat = an ? "R2" : "R5";
    end else if (!an) begin
      m_beat = m_beat + 2'd1;
      t_beat = (m_beat == 2'd0) ? "R9" : "R3";
    end else begin
      t_beat = "R4";
    end
    #1;
    t_addr = (sa | sb) ? "R2" : (m_mode ? "R8" : "R7");
    chk({t_beat, " beat"}, 32'(beat_out), 32'(m_beat));
    chk({t_addr, " addr"}, 32'(addr_out), 32'(exp_addr(m_base, m_beat, m_mode)));
    chk("R6 upper", 32'(addr_out[ADDR_W-1:2]), 32'(m_base[ADDR_W-1:2]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [ADDR_W-1:0] r;
    void'($urandom(32'd1234));
    start_a = 0; start_b = 0; adv_n = 1; mode = 1; addr_in = '0;
    m_base = '0; m_beat = 2'd0; m_mode = 1'b1;
    #7;
    // R1 in reset
    chk("R1 addr in reset", 32'(addr_out), 32'd0);
    chk("R1 beat in reset", 32'(beat_out), 32'd0);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 addr after reset", 32'(addr_out), 32'd0);
    chk("R1 beat after reset", 32'(beat_out), 32'd0);

    // R8 directed: start 01 interleaved -> 01,00,11,10, then wrap (R9)
    step(1, 0, 1, 1, 18'h2AB45 & ~18'h3 | 18'h1);
    chk("R8 beat0 low", 32'(addr_out[1:0]), 32'd1);
    step(0, 0, 0, 1, '0);
    chk("R8 beat1 low", 32'(addr_out[1:0]), 32'd0);
    step(0, 0, 0, 1, '1);
    chk("R8 beat2 low", 32'(addr_out[1:0]), 32'd3);
    step(0, 0, 0, 1, '0);
    chk("R8 beat3 low", 32'(addr_out[1:0]), 32'd2);
    step(0, 0, 0, 1, '1);
    chk("R9 wrap low", 32'(addr_out[1:0]), 32'd1);

    // R7 directed: start 10 linear -> 10,11,00,01
    step(0, 1, 1, 0, 18'h00012);
    step(0, 0, 0, 0, '1);
    chk("R7 beat1 low", 32'(addr_out[1:0]), 32'd3);
    step(0, 0, 0, 0, '1);
    chk("R7 beat2 low", 32'(addr_out[1:0]), 32'd0);
    // R4 hold, R6 addr_i ignored
    step(0, 0, 1, 0, 18'h3FFFF);
    chk("R4 hold low", 32'(addr_out[1:0]), 32'd0);
    // R5 both strobes with advance
    step(1, 1, 0, 0, 18'h1F00F);
    chk("R5 beat", 32'(beat_out), 32'd0);

    // random
    for (int i = 0; i < 3000; i++) begin
      logic sa, sb, md;
      r = ADDR_W'($urandom);
      sa = ($urandom % 8) == 0;
      sb = ($urandom % 8) == 0;
      md = (sa | sb) ? 1'($urandom) : m_mode;
      step(sa, sb, 1'($urandom % 3 == 0), md, r);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule